// File: doc/BRIEF.md
# Qualified Programmable Event Counter

This block is one programmable performance-monitoring counter. Every cycle it receives a bus of small per-lane increment values, grouped by event family, and a stored configuration. The configuration picks an event family by an 8-bit code and picks sub-events within it by an 8-bit lane mask. The block adds up the selected lanes to get a per-cycle event count. It then applies an optional threshold compare, an optional inversion of that compare, and an optional rising-edge reduction. The result is added to a 48-bit accumulator.

Software writes either the configuration or the accumulator through a single write port and always sees the accumulator value on an output. One event family treats its upper four mask bits as request-type filters. The block rejects a mask that sets filters without naming a lookup state: it raises a sticky error flag and holds the counter still until a legal configuration arrives. Occupancy-style families present the number of outstanding requests on a lane, so with no threshold the counter grows by a cycle-weighted amount.

Top module: `pec_counter`

## Requirements
- R1: After a synchronous reset the counter reads 0, the error flag reads 0, and the counter is disabled.
- R2: Writing with `wr_sel`=1 loads `wr_data` into the counter at the next clock edge, and this write takes priority over any increment in that cycle. Writing with `wr_sel`=0 stores a configuration from `wr_data`: code in [7:0], lane mask in [15:8], threshold in [23:16], edge enable at bit 24, invert at bit 25, enable at bit 26. The new configuration governs counting from the following cycle.
- R3: Lane l of family g is `evt_i[(g*8+l)*4 +: 4]`. Code 22h selects family 0, 34h family 1, 80h family 2 and 81h family 3. Any other code gives a per-cycle count of 0. The per-cycle count is the sum of the lanes whose mask bit is set.
- R4: With threshold 0 and edge enable off, the per-cycle count is added to the counter each cycle.
- R5: With a nonzero threshold and invert off, the counter advances by 1 in a cycle whose count is greater than or equal to the threshold, and otherwise holds.
- R6: With a nonzero threshold and invert on, the counter advances by 1 when the count is below the threshold. Invert has no effect when the threshold is 0.
- R7: With edge enable on, the counter advances by 1 only in a cycle where the condition is true and was false in the previous enabled cycle. The condition is the threshold compare, or "count nonzero" when the threshold is 0.
- R8: For code 34h, mask bits 0..3 are lookup-state lanes and bits 4..7 are filters. If any filter bit is set, the selected state lanes count only in cycles where at least one selected filter lane is nonzero.
- R9: A configuration write with code 34h, a nonzero filter nibble and a zero state nibble sets the error flag. While the flag is set the counter does not advance. The next legal configuration write clears the flag.
- R10: A configuration write or a disabled cycle clears the edge history. A condition already true in the first enabled cycle afterwards counts as one edge.
- R11: The counter is 48 bits wide and wraps from all ones to zero without any other effect.
- R12: With enable bit 26 clear, the counter holds its value whatever the event lanes carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 128 | Per-lane increment values, 4 families x 8 lanes x 4 bits |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 configuration, 1 counter |
| wr_data | input | 48 | Write data |
| cnt_o | output | 48 | Current counter value |
| cfg_err_o | output | 1 | Sticky illegal-mask flag |

## Verification
The hardest case to reach from the ports is the 48-bit wrap. Counting up naturally would take far too long, so the stimulus preloads the counter to just below all ones through the counter write and then lets a multi-count cycle carry it past zero. The edge history reset is also hard to observe. To reach it, the stimulus holds the condition true continuously and rewrites the same configuration, then checks that exactly one new edge is counted, and repeats this across a disable and re-enable. A reference model in the bench tracks counter, error flag and edge history every cycle under both directed and random lane traffic.

// File: rtl/pec_pkg.sv
package pec_pkg;

    localparam int LANES     = 8;
    localparam int LANE_W    = 4;
    localparam int FAMILIES  = 4;
    localparam int FAM_IDX_W = 2;
    localparam int FILT_LO   = 4;

    localparam logic [7:0] CODE_SNOOP = 8'h22;
    localparam logic [7:0] CODE_LOOK  = 8'h34;
    localparam logic [7:0] CODE_OCC   = 8'h80;
    localparam logic [7:0] CODE_REQ   = 8'h81;

    typedef struct packed {
        logic       en;
        logic       inv;
        logic       edge_en;
        logic [7:0] thr;
        logic [7:0] umask;
        logic [7:0] code;
    } pec_cfg_t;

    typedef struct packed {
        logic                 hit;
        logic                 filt;
        logic [FAM_IDX_W-1:0] idx;
    } fam_dec_t;

    function automatic fam_dec_t fam_decode(input logic [7:0] code);
        fam_dec_t d;
        d = '0;
        case (code)
            CODE_SNOOP: begin d.hit = 1'b1; d.idx = 2'd0; end
            CODE_LOOK:  begin d.hit = 1'b1; d.idx = 2'd1; d.filt = 1'b1; end
            CODE_OCC:   begin d.hit = 1'b1; d.idx = 2'd2; end
            CODE_REQ:   begin d.hit = 1'b1; d.idx = 2'd3; end
            default:    d = '0;
        endcase
        return d;
    endfunction

    function automatic logic mask_legal(input logic [7:0] code, input logic [7:0] umask);
        fam_dec_t d;
        d = fam_decode(code);
        return !(d.filt && (|umask[7:FILT_LO]) && !(|umask[FILT_LO-1:0]));
    endfunction

endpackage

// File: rtl/pec_evt_sel.sv
module pec_evt_sel
    import pec_pkg::*;
#(
    parameter int NFAM  = FAMILIES,
    parameter int NLANE = LANES,
    parameter int LW    = LANE_W,
    parameter int EW    = LANE_W + $clog2(LANES)
) (
    input  logic [NFAM*NLANE*LW-1:0] evt_i,
    input  logic [7:0]               code,
    input  logic [NLANE-1:0]         umask,
    output logic [EW-1:0]            cnt_o
);

    logic [LW-1:0] lane [NFAM][NLANE];

    for (genvar g = 0; g < NFAM; g++) begin : g_fam
        for (genvar l = 0; l < NLANE; l++) begin : g_lane
            assign lane[g][l] = evt_i[(g*NLANE+l)*LW +: LW];
        end
    end

    fam_dec_t      dec;
    logic          filt_req;
    logic          filt_seen;
    logic [EW-1:0] sum;

    always_comb begin
        dec       = fam_decode(code);
        sum       = '0;
        filt_seen = 1'b0;
        filt_req  = dec.filt && (|umask[NLANE-1:FILT_LO]);
        if (dec.hit) begin
            for (int l = 0; l < NLANE; l++) begin
                if (umask[l]) begin
                    if (dec.filt && l >= FILT_LO) begin
                        if (|lane[dec.idx][l]) filt_seen = 1'b1;
                    end else begin
                        sum = sum + EW'(lane[dec.idx][l]);
                    end
                end
            end
            if (filt_req && !filt_seen) sum = '0;
        end
        cnt_o = sum;
    end

endmodule

// File: rtl/pec_qual.sv
module pec_qual #(
    parameter int EW = 7,
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          clr,
    input  logic          edge_en,
    input  logic          inv,
    input  logic [TW-1:0] thr,
    input  logic [EW-1:0] cnt_i,
    output logic [EW-1:0] inc_o
);

    localparam int CMPW = (EW > TW) ? EW : TW;

    logic [CMPW-1:0] cnt_x, thr_x;
    logic            thr_on, cond, prev_q;

    assign cnt_x  = CMPW'(cnt_i);
    assign thr_x  = CMPW'(thr);
    assign thr_on = |thr;

    always_comb begin
        if (thr_on) cond = inv ? (cnt_x < thr_x) : (cnt_x >= thr_x);
        else        cond = |cnt_i;
    end

    always_comb begin
        if (!run)         inc_o = '0;
        else if (edge_en) inc_o = EW'(cond && !prev_q);
        else if (thr_on)  inc_o = EW'(cond);
        else              inc_o = cnt_i;
    end

    always_ff @(posedge clk) begin
        if (rst || clr || !run) prev_q <= 1'b0;
        else                    prev_q <= cond;
    end

    // R5
    thr_unit_chk: assert property (@(posedge clk) disable iff (rst)
        (run && thr_on) |-> (inc_o <= EW'(1)));

    // R7
    edge_once_chk: assert property (@(posedge clk) disable iff (rst)
        (run && edge_en && inc_o != '0 && !clr) |=> (inc_o == '0));

    // R10
    edge_fresh_chk: assert property (@(posedge clk) disable iff (rst)
        (clr || !run) |=> !prev_q);

endmodule

// File: rtl/pec_accum.sv
module pec_accum #(
    parameter int CW = 48,
    parameter int EW = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic [EW-1:0] inc_i,
    output logic [CW-1:0] cnt_o
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (load) cnt_q <= load_val;
        else           cnt_q <= cnt_q + CW'(inc_i);
    end

    assign cnt_o = cnt_q;

    // R2
    load_prio_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt_q == $past(load_val)));

    // R11
    wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && (&cnt_q) && inc_i == EW'(1)) |=> (cnt_q == '0));

endmodule

// File: rtl/pec_counter.sv
module pec_counter
    import pec_pkg::*;
#(
    parameter int CW    = 48,
    parameter int NFAM  = FAMILIES,
    parameter int NLANE = LANES,
    parameter int LW    = LANE_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NFAM*NLANE*LW-1:0] evt_i,
    input  logic                     wr_en,
    input  logic                     wr_sel,
    input  logic [CW-1:0]            wr_data,
    output logic [CW-1:0]            cnt_o,
    output logic                     cfg_err_o
);

    localparam int EW   = LW + $clog2(NLANE);
    localparam int CFGW = $bits(pec_cfg_t);

    pec_cfg_t      cfg_q, cfg_new;
    logic          err_q, run, cfg_wr, cnt_wr, new_legal;
    logic [EW-1:0] ev_cnt, inc;

    assign cfg_wr    = wr_en && !wr_sel;
    assign cnt_wr    = wr_en && wr_sel;
    assign cfg_new   = pec_cfg_t'(wr_data[CFGW-1:0]);
    assign new_legal = mask_legal(cfg_new.code, cfg_new.umask);
    assign run       = cfg_q.en && !err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            err_q <= 1'b0;
        end else if (cfg_wr) begin
            cfg_q <= cfg_new;
            err_q <= !new_legal;
        end
    end

    pec_evt_sel #(.NFAM(NFAM), .NLANE(NLANE), .LW(LW), .EW(EW)) u_sel (
        .evt_i (evt_i),
        .code  (cfg_q.code),
        .umask (cfg_q.umask),
        .cnt_o (ev_cnt)
    );

    pec_qual #(.EW(EW), .TW(8)) u_qual (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .clr     (cfg_wr),
        .edge_en (cfg_q.edge_en),
        .inv     (cfg_q.inv),
        .thr     (cfg_q.thr),
        .cnt_i   (ev_cnt),
        .inc_o   (inc)
    );

    pec_accum #(.CW(CW), .EW(EW)) u_acc (
        .clk      (clk),
        .rst      (rst),
        .load     (cnt_wr),
        .load_val (wr_data),
        .inc_i    (inc),
        .cnt_o    (cnt_o)
    );

    assign cfg_err_o = err_q;

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (err_q && !(cfg_wr && new_legal)) |=> err_q);

    // R9
    err_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (err_q && !cnt_wr) |=> $stable(cnt_o));

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg_q.en && !cnt_wr) |=> $stable(cnt_o));

endmodule

// File: tb/sim_pec_counter.sv
module sim_pec_counter;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [127:0] evt = '0;
    logic         wr_en = 1'b0;
    logic         wr_sel = 1'b0;
    logic [47:0]  wr_data = '0;
    logic [47:0]  cnt_o;
    logic         cfg_err_o;

    always #5 clk = ~clk;

    pec_counter u0 (
        .clk(clk), .rst(rst), .evt_i(evt), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .cnt_o(cnt_o), .cfg_err_o(cfg_err_o)
    );

    int    checks = 0;
    int    failures = 0;
    bit    done = 0;
    string phase = "R1";

    logic [47:0] m_cnt = '0;
    logic [7:0]  m_code = '0, m_um = '0, m_thr = '0;
    bit          m_edge = 0, m_inv = 0, m_en = 0, m_err = 0, m_prev = 0;

    function automatic int lane_val(int g, int l);
        return int'(evt[(g*8+l)*4 +: 4]);
    endfunction

    function automatic int ev_count(logic [7:0] code, logic [7:0] um);
        int g, s;
        bit any;
        s = 0;
        case (code)
            8'h22: g = 0;
            8'h34: g = 1;
            8'h80: g = 2;
            8'h81: g = 3;
            default: return 0;
        endcase
        if (g == 1) begin
            for (int b = 0; b < 4; b++) if (um[b]) s += lane_val(1, b);
            if (um[7:4] != 0) begin
                any = 0;
                for (int b = 4; b < 8; b++) if (um[b] && lane_val(1, b) != 0) any = 1;
                if (!any) s = 0;
            end
        end else begin
            for (int b = 0; b < 8; b++) if (um[b]) s += lane_val(g, b);
        end
        return s;
    endfunction

    task automatic model_step();
        int  c, inc;
        bit  run, cond, nprev;
        if (rst) begin
            m_cnt = '0; m_code = '0; m_um = '0; m_thr = '0;
            m_edge = 0; m_inv = 0; m_en = 0; m_err = 0; m_prev = 0;
            return;
        end
        run = m_en && !m_err;
        c = ev_count(m_code, m_um);
        if (m_thr != 0) cond = m_inv ? (c < int'(m_thr)) : (c >= int'(m_thr));
        else            cond = (c != 0);
        inc = 0;
        if (run) begin
            if (m_edge)          inc = (cond && !m_prev) ? 1 : 0;
            else if (m_thr != 0) inc = cond ? 1 : 0;
            else                 inc = c;
        end
        nprev = (run && !(wr_en && !wr_sel)) ? cond : 0;
        if (wr_en && wr_sel) m_cnt = wr_data;
        else                 m_cnt = m_cnt + 48'(inc);
        if (wr_en && !wr_sel) begin
            m_code = wr_data[7:0];
            m_um   = wr_data[15:8];
            m_thr  = wr_data[23:16];
            m_edge = wr_data[24];
            m_inv  = wr_data[25];
            m_en   = wr_data[26];
            m_err  = (m_code == 8'h34) && (m_um[7:4] != 0) && (m_um[3:0] == 0);
        end
        m_prev = nprev;
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        checks++;
        if (cnt_o !== m_cnt) begin
            failures++;
            $display("FAIL %s counter actual=%0h expected=%0h", phase, cnt_o, m_cnt);
        end
        checks++;
        if (cfg_err_o !== m_err) begin
            failures++;
            $display("FAIL %s error flag actual=%0b expected=%0b", phase, cfg_err_o, m_err);
        end
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic set_lane(int g, int l, int v);
        evt[(g*8+l)*4 +: 4] = 4'(v);
    endtask

    task automatic cfg(logic [7:0] code, logic [7:0] um, logic [7:0] thr,
                       bit ed, bit iv, bit en);
        wr_en = 1; wr_sel = 0;
        wr_data = {21'd0, en, iv, ed, thr, um, code};
        tick();
        wr_en = 0;
    endtask

    task automatic load_cnt(logic [47:0] v);
        wr_en = 1; wr_sel = 1; wr_data = v;
        tick();
        wr_en = 0;
    endtask

    task automatic rand_ticks(int n);
        for (int i = 0; i < n; i++) begin
            evt = {$urandom, $urandom, $urandom, $urandom};
            tick();
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        void'($urandom(7));
        phase = "R1";
        ticks(2);
        rst = 0;
        ticks(2);

        phase = "R4";
        cfg(8'h22, 8'h05, 8'h00, 0, 0, 1);
        rand_ticks(20);
        phase = "R3";
        cfg(8'h81, 8'hFF, 8'h00, 0, 0, 1);
        rand_ticks(10);
        cfg(8'h55, 8'hFF, 8'h00, 0, 0, 1);
        rand_ticks(10);
        cfg(8'h80, 8'h00, 8'h00, 0, 0, 1);
        rand_ticks(5);

        phase = "R2";
        cfg(8'h80, 8'hFF, 8'h00, 0, 0, 1);
        evt = {32{4'hF}};
        tick();
        load_cnt(48'h0000_1234_5678);
        tick();
        load_cnt(48'h0);

        phase = "R5";
        cfg(8'h80, 8'h0F, 8'd30, 0, 0, 1);
        rand_ticks(30);
        phase = "R6";
        cfg(8'h80, 8'h0F, 8'd30, 0, 1, 1);
        rand_ticks(30);
        cfg(8'h80, 8'h0F, 8'd0, 0, 1, 1);
        rand_ticks(10);

        phase = "R7";
        evt = '0;
        cfg(8'h22, 8'h01, 8'd0, 1, 0, 1);
        set_lane(0, 0, 3); ticks(4);
        set_lane(0, 0, 0); ticks(2);
        set_lane(0, 0, 1); ticks(3);
        cfg(8'h22, 8'h03, 8'd5, 1, 0, 1);
        set_lane(0, 0, 3); set_lane(0, 1, 3); ticks(3);
        set_lane(0, 1, 0); ticks(2);
        set_lane(0, 1, 2); ticks(2);
        rand_ticks(20);

        phase = "R10";
        evt = '0;
        set_lane(0, 0, 4);
        cfg(8'h22, 8'h01, 8'd0, 1, 0, 1);
        ticks(3);
        cfg(8'h22, 8'h01, 8'd0, 1, 0, 1);
        ticks(3);
        cfg(8'h22, 8'h01, 8'd0, 1, 0, 0);
        ticks(2);
        cfg(8'h22, 8'h01, 8'd0, 1, 0, 1);
        ticks(3);

        phase = "R8";
        evt = '0;
        cfg(8'h34, 8'h13, 8'd0, 0, 0, 1);
        set_lane(1, 0, 2); set_lane(1, 1, 5); set_lane(1, 2, 7);
        ticks(2);
        set_lane(1, 4, 1); ticks(2);
        set_lane(1, 5, 3); set_lane(1, 4, 0); ticks(2);
        cfg(8'h34, 8'h0E, 8'd0, 0, 0, 1);
        rand_ticks(10);
        cfg(8'h34, 8'hC9, 8'd0, 0, 0, 1);
        rand_ticks(15);

        phase = "R9";
        cfg(8'h34, 8'h30, 8'd0, 0, 0, 1);
        rand_ticks(8);
        cfg(8'h22, 8'h30, 8'd0, 0, 0, 1);
        rand_ticks(4);
        cfg(8'h34, 8'hF0, 8'd0, 0, 0, 1);
        rand_ticks(4);
        cfg(8'h34, 8'h11, 8'd0, 0, 0, 1);
        rand_ticks(6);

        phase = "R11";
        cfg(8'h80, 8'h01, 8'd0, 0, 0, 1);
        evt = '0;
        load_cnt(48'hFFFF_FFFF_FFFE);
        set_lane(2, 0, 3);
        ticks(2);
        cfg(8'h80, 8'h01, 8'd1, 0, 0, 1);
        load_cnt(48'hFFFF_FFFF_FFFF);
        ticks(2);

        phase = "R12";
        cfg(8'h80, 8'hFF, 8'd0, 0, 0, 0);
        rand_ticks(15);

        phase = "R3";
        for (int k = 0; k < 40; k++) begin
            logic [7:0] codes [4] = '{8'h22, 8'h34, 8'h80, 8'h81};
            cfg(codes[$urandom % 4], 8'($urandom), 8'($urandom % 12),
                1'($urandom), 1'($urandom), 1'(($urandom % 4) != 0));
            rand_ticks(12);
        end

        report();
    end

endmodule